// File: doc/BRIEF.md
# Pulse-Swallow PLL Feedback Divider

This block divides a VCO-rate clock down to the PLL reference rate. A 14/15 two-modulus prescaler feeds a program counter (P) and a swallow counter (Q). For the first Q+1 prescaler cycles of each output period the prescaler divides by 15. For the remaining cycles it divides by 14. At the end of every period the block emits one feedback pulse, one clock wide, toward the phase comparator.

The divider settings live in a 16-bit control word that software writes through byte lanes. Once software sets a lock bit in that word, the settings can no longer change until the next reset. The top bit of the word reads back the level of the slow reference clock. Software uses it to time a frequency change.

The control word sits in the same clock domain as the divider. New settings are taken up only at a period boundary.

Top module: `pll_fbdiv`

## Requirements
- R1: While reset is asserted, and after it is released, `rd_data` reads 0x0123 (ref low). P=0x23, Q=0x1, lock clear, and the feedback period is 506 clocks.
- R2: For Q ≤ P, `fb_pulse` is high for exactly one clock per period, and consecutive pulses are 14·(P+1)+(Q+1) clocks apart.
- R3: For Q > P, every prescaler cycle divides by 15, so the period is 15·(P+1) clocks.
- R4: A write during a period does not change that period. The new P/Q set the length of the following period.
- R5: `wr_be[0]` writes P from `wr_data[7:0]`. `wr_be[1]` writes Q from `wr_data[11:8]` and the lock bit from `wr_data[14]`. A lane that is not enabled keeps its value.
- R6: While the lock bit (bit 14) is 1, every write is ignored: readback and period stay unchanged. Only reset clears the lock.
- R7: `rd_data[15]` shows `ref_clk` after two clock edges of synchronization. It is 0 after one edge and 1 after the second. Bits 13:12 always read 0, and writes to bits 15:12 other than bit 14 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | VCO-rate clock, clocks divider and control word |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_clk | input | 1 | Slow reference clock, asynchronous |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 2 | Byte enables, bit 0 = low byte, bit 1 = high byte |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Control word readback: {ref, lock, 2'b00, Q[3:0], P[7:0]} |
| fb_pulse | output | 1 | One-clock feedback pulse at the end of each period |

## Verification
Assertions check several properties on every clock. The feedback pulse never lasts two clocks, and the counters stay within their moduli. The active divider settings change only in the cycle after a period ends. The lock bit never falls, and locked fields never move. The period lengths themselves, the clamp when Q exceeds P, byte-lane selection, the two-edge reference latency and the reset value can only be shown by the bench. It does this by measuring pulse spacing and readback across its write scenarios.

// File: rtl/pll_fbdiv_pkg.sv
package pll_fbdiv_pkg;
  localparam int CW_W     = 16;
  localparam int P_W      = 8;
  localparam int Q_W      = 4;
  localparam int P_LSB    = 0;
  localparam int Q_LSB    = 8;
  localparam int LOCK_BIT = 14;
  localparam int REF_BIT  = 15;
  localparam logic [CW_W-1:0] CW_RESET = 16'h0123;
  localparam logic [P_W-1:0]  P_RESET  = CW_RESET[P_LSB +: P_W];
  localparam logic [Q_W-1:0]  Q_RESET  = CW_RESET[Q_LSB +: Q_W];
endpackage

// File: rtl/fbdiv_sync2.sv
module fbdiv_sync2 #(
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_LVL;
      s2_q <= RST_LVL;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/fbdiv_ctrl_word.sv
module fbdiv_ctrl_word
  import pll_fbdiv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_s,
  input  logic            wr_en,
  input  logic [1:0]      wr_be,
  input  logic [CW_W-1:0] wr_data,
  output logic [P_W-1:0]  p_cfg,
  output logic [Q_W-1:0]  q_cfg,
  output logic [CW_W-1:0] rd_data
);
  logic [P_W-1:0] p_q, p_d;
  logic [Q_W-1:0] q_q, q_d;
  logic           lock_q, lock_d;
  logic           wr_ok;

  assign wr_ok = wr_en & ~lock_q;

  always_comb begin
    p_d    = p_q;
    q_d    = q_q;
    lock_d = lock_q;
    if (wr_ok) begin
      if (wr_be[0]) p_d = wr_data[P_LSB +: P_W];
      if (wr_be[1]) begin
        q_d    = wr_data[Q_LSB +: Q_W];
        lock_d = wr_data[LOCK_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q    <= P_RESET;
      q_q    <= Q_RESET;
      lock_q <= 1'b0;
    end else begin
      p_q    <= p_d;
      q_q    <= q_d;
      lock_q <= lock_d;
    end
  end

  assign p_cfg   = p_q;
  assign q_cfg   = q_q;
  assign rd_data = {ref_s, lock_q, 2'b00, q_q, p_q};

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  assert_locked_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(p_q) && $stable(q_q)));
endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow #(
  parameter int PRE_BASE = 14,
  parameter int PW       = 8,
  parameter int QW       = 4,
  parameter logic [PW-1:0] P_INIT = '0,
  parameter logic [QW-1:0] Q_INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] p_cfg,
  input  logic [QW-1:0] q_cfg,
  output logic          fb_pulse
);
  localparam int CNTW = $clog2(PRE_BASE + 1);

  logic [CNTW-1:0] pre_q, pre_d;
  logic [PW-1:0]   prog_q, prog_d, p_act_q, p_act_d;
  logic [QW-1:0]   q_act_q, q_act_d;
  logic            fb_q, fb_d;
  logic            swallow, pre_last, prog_last, period_end;

  assign swallow    = ({{(PW-QW){1'b0}}, q_act_q} >= prog_q);
  assign pre_last   = swallow ? (pre_q == CNTW'(PRE_BASE))
                              : (pre_q == CNTW'(PRE_BASE - 1));
  assign prog_last  = (prog_q == p_act_q);
  assign period_end = pre_last & prog_last;

  always_comb begin
    pre_d   = pre_q + 1'b1;
    prog_d  = prog_q;
    p_act_d = p_act_q;
    q_act_d = q_act_q;
    fb_d    = period_end;
    if (pre_last) begin
      pre_d = '0;
      if (prog_last) begin
        prog_d  = '0;
        p_act_d = p_cfg;
        q_act_d = q_cfg;
      end else begin
        prog_d = prog_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      prog_q  <= '0;
      p_act_q <= P_INIT;
      q_act_q <= Q_INIT;
      fb_q    <= 1'b0;
    end else begin
      pre_q   <= pre_d;
      prog_q  <= prog_d;
      p_act_q <= p_act_d;
      q_act_q <= q_act_d;
      fb_q    <= fb_d;
    end
  end

  assign fb_pulse = fb_q;

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fb_q |=> !fb_q);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_q <= p_act_q) && (pre_q <= CNTW'(PRE_BASE)));
  assert_load_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> ($stable(p_act_q) && $stable(q_act_q)));
endmodule

// File: rtl/pll_fbdiv.sv
module pll_fbdiv
  import pll_fbdiv_pkg::*;
#(
  parameter int PRE_BASE = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_clk,
  input  logic        wr_en,
  input  logic [1:0]  wr_be,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        fb_pulse
);
  logic           rst_s_n;
  logic           ref_s;
  logic [P_W-1:0] p_cfg;
  logic [Q_W-1:0] q_cfg;

  fbdiv_sync2 #(.RST_LVL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_s_n));

  fbdiv_sync2 #(.RST_LVL(1'b0)) u_ref_sync (
    .clk(clk), .rst_n(rst_s_n), .d(ref_clk), .q(ref_s));

  fbdiv_ctrl_word u_cw (
    .clk(clk), .rst_n(rst_s_n), .ref_s(ref_s),
    .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .p_cfg(p_cfg), .q_cfg(q_cfg), .rd_data(rd_data));

  fbdiv_swallow #(
    .PRE_BASE(PRE_BASE), .PW(P_W), .QW(Q_W),
    .P_INIT(P_RESET), .Q_INIT(Q_RESET)
  ) u_div (
    .clk(clk), .rst_n(rst_s_n), .p_cfg(p_cfg), .q_cfg(q_cfg),
    .fb_pulse(fb_pulse));
endmodule

// File: tb/sim_pll_fbdiv.sv
module sim_pll_fbdiv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_clk = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0000;
  logic [15:0] rd_data;
  logic        fb_pulse;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pll_fbdiv u0 (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .wr_en(wr_en),
    .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data), .fb_pulse(fb_pulse));

  // {byte enables, write data, expected readback, expected period}
  typedef struct packed {
    logic [1:0]  be;
    logic [15:0] data;
    logic [15:0] rd;
    logic [15:0] n;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b11, 16'h0123, 16'h0123, 16'd506},   // R2 default ratio
    '{2'b11, 16'h0000, 16'h0000, 16'd15},    // R2 P=0 Q=0
    '{2'b11, 16'h0300, 16'h0300, 16'd15},    // R3 Q>P: 15*(0+1)
    '{2'b11, 16'hB505, 16'h0505, 16'd90},    // R7 bits 15,13,12 ignored
    '{2'b01, 16'hFFFF, 16'h05FF, 16'd3590},  // R5 low lane only
    '{2'b10, 16'h0A00, 16'h0AFF, 16'd3595},  // R5 high lane only
    '{2'b11, 16'h0F10, 16'h0F10, 16'd254},   // R2 Q near P
    '{2'b11, 16'h020A, 16'h020A, 16'd157}    // R2
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (fb_pulse !== 1'b1);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (fb_pulse !== 1'b1);
  endtask

  task automatic write_word(input logic [1:0] be, input logic [15:0] d);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int n1, n2, prev;
    repeat (3) @(negedge clk);
    check("R1 rd during reset", rd_data, 16'h0123);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rd after reset", rd_data, 16'h0123);

    // R7 reference sync latency
    ref_clk = 1'b1;
    @(negedge clk);
    check("R7 ref after 1 edge", rd_data[15], 0);
    @(negedge clk);
    check("R7 ref after 2 edges", rd_data[15], 1);
    ref_clk = 1'b0;
    repeat (2) @(negedge clk);

    wait_pulse();
    measure(n1);
    check("R1 default period", n1, 506);
    prev = 506;

    foreach (VECS[i]) begin
      write_word(VECS[i].be, VECS[i].data);
      check("R5 readback", rd_data, VECS[i].rd);
      measure(n1);
      check("R4 period in progress", n1 + 1, prev);
      measure(n2);
      check("R2 new period", n2, VECS[i].n);
      prev = VECS[i].n;
    end

    // R6 lock: set it, then try to change settings
    write_word(2'b11, 16'h4123);
    check("R6 lock set readback", rd_data, 16'h4123);
    measure(n1);
    check("R4 period before lock", n1 + 1, prev);
    write_word(2'b11, 16'h0000);
    check("R6 full write ignored", rd_data, 16'h4123);
    write_word(2'b01, 16'h0011);
    check("R6 byte write ignored", rd_data, 16'h4123);
    measure(n1);
    measure(n2);
    check("R6 period unchanged", n2, 506);

    // reset clears lock
    rst_n = 1'b0;
    @(negedge clk);
    check("R6 reset clears lock", rd_data, 16'h0123);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    write_word(2'b11, 16'h0000);
    check("R6 writable after reset", rd_data, 16'h0000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule